// File: doc/BRIEF.md
# Core Clock Ratio Jog Controller

This block lets software change the clock multiplier of each processor core while the chip runs. Three 32-bit registers sit on a simple register bus: a read-only status register that reports the ratio each core is running at, a jog request register with one ratio field and one speed-range bit per core, and a power-management control register that holds a jog-start bit, a four-bit interrupt-mask field and a sticky error flag. Software loads the requested ratios and writes the jog-start bit. The block then runs a timed lock sequence, drives the accepted ratios onto the per-core outputs for the clock generator, and clears the jog-start bit so that software can poll for completion.

Each core has an allowed ratio window. Its lower bound is a parameter. Its upper bound is the core's boot ratio, and that bound is never above the supported maximum of 4. A request outside the window leaves that core on its previous ratio and speed bit and raises the error flag. Core frequency is the system clock times the applied ratio. Software confirms a change by reading the status register.

The register bus has no data stream and no back-pressure. A write is taken on every clock edge where `reg_wr_en` is high. Read data is a combinational function of `reg_addr`. Ratio fields sit at bit 16 + 8 × core, so at most two cores fit in the 32-bit registers.

Top module: `jog_ctrl`

## Requirements
- R1: Out of reset, `core_ratio_o` carries each core's boot ratio and `core_fast_o` is all ones. The status register reports the boot ratios. The request register holds the boot ratios with every speed bit set. The control register reads 0.
- R2: Register addresses are 0x00 for status (read-only), 0x04 for the jog request register and 0x08 for control. For core i, the ratio field is bits [16+8i +: 6] in both status and request, and the speed bit is request bit 12+i. In control, the jog-start bit is bit 21, the mask field is bits 11:8 and the error flag is bit 0.
- R3: A control write with bit 21 set while idle starts a jog. Bit 21 reads 1 for exactly LOCK_CYCLES cycles after the accepting edge. On the edge that clears it, the per-core outputs take their new values.
- R4: At completion, a core whose requested ratio lies between MIN_RATIO and its boot ratio (inclusive) takes the requested ratio and speed bit. Any other core keeps its previous ratio and speed bit.
- R5: The error flag (control bit 0) is set when a completing jog rejects any core. It stays set until software writes 1 to bit 0. If the clearing write lands on the completion edge of a rejecting jog, the flag stays set.
- R6: Writes to the request register while bit 21 reads 1 have no effect on its contents.
- R7: After completion, each status ratio field equals the ratio applied to that core.
- R8: The mask field is plain read/write storage, and writing it does not start a jog.
- R9: A control write during a jog, with bit 21 at 0 or 1, neither aborts nor restarts the lock countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| core_ratio_o | output | NUM_CORES*RATIO_W | Applied ratio per core, core 0 in the low bits |
| core_fast_o | output | NUM_CORES | Applied speed-range bit per core |

## Verification
Two functions can act on the same edge. A rejecting jog sets the error flag on its completion edge, and software may clear that flag with a write on the same edge. The bench places the clearing write exactly on the completion edge of a jog with an out-of-range ratio, and it also inserts a second start request partway through that jog. It then expects the flag to read 1, the jog bit to clear on the original schedule, and no new countdown to begin.

// File: rtl/jog_pkg.sv
package jog_pkg;
  localparam int REG_W = 32;
  localparam logic [7:0] ADDR_STATUS  = 8'h00;
  localparam logic [7:0] ADDR_REQUEST = 8'h04;
  localparam logic [7:0] ADDR_CONTROL = 8'h08;
  localparam int BIT_START   = 21;
  localparam int BIT_ERR     = 0;
  localparam int MASK_LSB    = 8;
  localparam int MASK_W      = 4;
  localparam int FAST_LSB    = 12;
  localparam int RATIO_BASE  = 16;
  localparam int RATIO_PITCH = 8;

  function automatic int ratio_lsb(input int core);
    return RATIO_BASE + RATIO_PITCH * core;
  endfunction
endpackage

// File: rtl/jog_lock_timer.sv
module jog_lock_timer #(
  parameter int LOCK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(LOCK_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> (busy_o && $past(cnt_q) == cnt_q + 1'b1)); // R9
endmodule

// File: rtl/jog_core_slot.sv
module jog_core_slot #(
  parameter int RATIO_W    = 6,
  parameter int MIN_RATIO  = 2,
  parameter int MAX_RATIO  = 4,
  parameter int BOOT_RATIO = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               apply,
  input  logic [RATIO_W-1:0] req_ratio,
  input  logic               req_fast,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               fast_o,
  output logic               reject_o
);
  localparam int CEIL_I = (BOOT_RATIO > MAX_RATIO) ? MAX_RATIO : BOOT_RATIO;
  localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] CEIL  = RATIO_W'(CEIL_I);

  logic [RATIO_W-1:0] ratio_q;
  logic               fast_q;
  logic               in_range;

  assign in_range = (req_ratio >= FLOOR) && (req_ratio <= CEIL);
  assign reject_o = apply && !in_range;
  assign ratio_o  = ratio_q;
  assign fast_o   = fast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= CEIL;
      fast_q  <= 1'b1;
    end else if (apply && in_range) begin
      ratio_q <= req_ratio;
      fast_q  <= req_fast;
    end
  end

  AST_RATIO_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q >= FLOOR) && (ratio_q <= CEIL)); // R4
  AST_HOLD_UNLESS_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(ratio_q) && $stable(fast_q))); // R4
endmodule

// File: rtl/jog_ctrl.sv
module jog_ctrl
  import jog_pkg::*;
#(
  parameter int NUM_CORES   = 2,
  parameter int RATIO_W     = 6,
  parameter int MIN_RATIO   = 2,
  parameter int MAX_RATIO   = 4,
  parameter logic [NUM_CORES*RATIO_W-1:0] BOOT_RATIOS = {6'd4, 6'd3},
  parameter int LOCK_CYCLES = 64,
  parameter int ADDR_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr_en,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [REG_W-1:0]             reg_wdata,
  output logic [REG_W-1:0]             reg_rdata,
  output logic [NUM_CORES*RATIO_W-1:0] core_ratio_o,
  output logic [NUM_CORES-1:0]         core_fast_o
);
  localparam int VEC_W = NUM_CORES * RATIO_W;

  logic [VEC_W-1:0]     req_ratio_q;
  logic [NUM_CORES-1:0] req_fast_q;
  logic [MASK_W-1:0]    mask_q;
  logic                 err_q;
  logic                 busy, done, start;
  logic                 wr_req, wr_ctl;
  logic [NUM_CORES-1:0] reject;
  logic [VEC_W-1:0]     applied;

  assign wr_req = reg_wr_en && (reg_addr == ADDR_W'(ADDR_REQUEST)) && !busy;
  assign wr_ctl = reg_wr_en && (reg_addr == ADDR_W'(ADDR_CONTROL));
  assign start  = wr_ctl && reg_wdata[BIT_START];

  jog_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy_o (busy),
    .done_o (done)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    jog_core_slot #(
      .RATIO_W    (RATIO_W),
      .MIN_RATIO  (MIN_RATIO),
      .MAX_RATIO  (MAX_RATIO),
      .BOOT_RATIO (int'(BOOT_RATIOS[c*RATIO_W +: RATIO_W]))
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .apply     (done),
      .req_ratio (req_ratio_q[c*RATIO_W +: RATIO_W]),
      .req_fast  (req_fast_q[c]),
      .ratio_o   (applied[c*RATIO_W +: RATIO_W]),
      .fast_o    (core_fast_o[c]),
      .reject_o  (reject[c])
    );
  end

  assign core_ratio_o = applied;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ratio_q <= BOOT_RATIOS;
      req_fast_q  <= '1;
    end else if (wr_req) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        req_ratio_q[c*RATIO_W +: RATIO_W] <= reg_wdata[ratio_lsb(c) +: RATIO_W];
        req_fast_q[c] <= reg_wdata[FAST_LSB + c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_ctl) mask_q <= reg_wdata[MASK_LSB +: MASK_W];
      if (done && (|reject))                 err_q <= 1'b1;
      else if (wr_ctl && reg_wdata[BIT_ERR]) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(ADDR_STATUS): begin
        for (int c = 0; c < NUM_CORES; c++)
          reg_rdata[ratio_lsb(c) +: RATIO_W] = applied[c*RATIO_W +: RATIO_W];
      end
      ADDR_W'(ADDR_REQUEST): begin
        for (int c = 0; c < NUM_CORES; c++) begin
          reg_rdata[ratio_lsb(c) +: RATIO_W] = req_ratio_q[c*RATIO_W +: RATIO_W];
          reg_rdata[FAST_LSB + c] = req_fast_q[c];
        end
      end
      ADDR_W'(ADDR_CONTROL): begin
        reg_rdata[BIT_START]             = busy;
        reg_rdata[MASK_LSB +: MASK_W]    = mask_q;
        reg_rdata[BIT_ERR]               = err_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(req_ratio_q) && $stable(req_fast_q))); // R6
  AST_ERR_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (|reject)) |=> err_q); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_ctl && reg_wdata[BIT_ERR])) |=> err_q); // R5
  AST_OUT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(core_ratio_o)); // R3
endmodule

// File: tb/tb_jog_ctrl.sv
`timescale 1ns/1ps
module tb_jog_ctrl;
  localparam int L = 5;
  localparam int NC = 2;
  localparam int RW = 6;
  localparam int MINR = 2;
  localparam int CEIL0 = 3;
  localparam int CEIL1 = 4;
  localparam logic [7:0] A_ST = 8'h00, A_RQ = 8'h04, A_CT = 8'h08;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NC*RW-1:0] ratio_o;
  logic [NC-1:0] fast_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int er0, er1;
  logic ef0, ef1, eerr;

  always #10 clk = ~clk;

  jog_ctrl #(
    .NUM_CORES(NC), .RATIO_W(RW), .MIN_RATIO(MINR), .MAX_RATIO(4),
    .BOOT_RATIOS({6'd4, 6'd3}), .LOCK_CYCLES(L), .ADDR_W(8)
  ) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata),
    .core_ratio_o(ratio_o), .core_fast_o(fast_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] st_word(input int r0, input int r1);
    return (32'(r1) << 24) | (32'(r0) << 16);
  endfunction

  function automatic logic [31:0] ct_word(input logic b, input logic [3:0] m, input logic e);
    return (32'(b) << 21) | (32'(m) << 8) | 32'(e);
  endfunction

  task automatic chk_outputs(input string tag);
    logic [31:0] v;
    chk({tag, " ratio_o"}, 32'(ratio_o), 32'((er1 << 6) | er0));
    chk({tag, " fast_o"}, 32'(fast_o), 32'({ef1, ef0}));
    rd(A_ST, v);
    chk({tag, " R7 status"}, v, st_word(er0, er1));
  endtask

  task automatic model_done(input int r0, input logic f0, input int r1, input logic f1);
    if (r0 >= MINR && r0 <= CEIL0) begin er0 = r0; ef0 = f0; end else eerr = 1'b1;
    if (r1 >= MINR && r1 <= CEIL1) begin er1 = r1; ef1 = f1; end else eerr = 1'b1;
  endtask

  task automatic jog(input int r0, input logic f0, input int r1, input logic f1, input logic [3:0] m);
    logic [31:0] v;
    wr(A_RQ, st_word(r0, r1) | (32'(f1) << 13) | (32'(f0) << 12));
    wr(A_CT, ct_word(1'b1, m, 1'b0));
    rd(A_CT, v);
    chk("R3 busy after start", v, ct_word(1'b1, m, eerr));
    repeat (L - 1) @(negedge clk);
    rd(A_CT, v);
    chk("R3 busy on last lock cycle", 32'(v[21]), 32'd1);
    chk_outputs("R3 outputs held during lock");
    @(negedge clk);
    model_done(r0, f0, r1, f1);
    rd(A_CT, v);
    chk("R3/R5 control after completion", v, ct_word(1'b0, m, eerr));
    chk_outputs("R4 applied");
    wr(A_CT, ct_word(1'b0, m, 1'b1));
    eerr = 1'b0;
    rd(A_CT, v);
    chk("R5 error cleared by write-1", v, ct_word(1'b0, m, 1'b0));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    er0 = CEIL0; er1 = CEIL1; ef0 = 1'b1; ef1 = 1'b1; eerr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_outputs("R1 reset");
    rd(A_RQ, v);
    chk("R1 request reset", v, st_word(CEIL0, CEIL1) | 32'h3000);
    rd(A_CT, v);
    chk("R1 control reset", v, 32'h0);

    // R2 R3 R4 R5 R7 sweep of requested ratios 0..7 on both cores
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        jog(a, a[0], b, ~b[0], 4'(a + b));
      end
    end

    // R8 mask field is plain storage, no jog
    wr(A_CT, ct_word(1'b0, 4'hA, 1'b0));
    rd(A_CT, v);
    chk("R8 mask readback", v, ct_word(1'b0, 4'hA, 1'b0));
    @(negedge clk);
    chk_outputs("R8 no jog from mask write");
    wr(A_CT, 32'h0);
    rd(A_CT, v);
    chk("R8 mask cleared", v, 32'h0);

    // R6 request writes ignored while busy
    wr(A_RQ, st_word(2, 3) | 32'h1000);
    wr(A_CT, ct_word(1'b1, 4'h0, 1'b0));
    wr(A_RQ, st_word(3, 2) | 32'h2000);
    rd(A_RQ, v);
    chk("R6 request unchanged while busy", v, st_word(2, 3) | 32'h1000);
    repeat (L) @(negedge clk);
    model_done(2, 1'b1, 3, 1'b0);
    rd(A_RQ, v);
    chk("R6 request after completion", v, st_word(2, 3) | 32'h1000);
    chk_outputs("R6 applied value is pre-busy request");

    // R9 + R5 same-edge: restart attempt mid-jog, error clear on completion edge
    wr(A_RQ, st_word(7, 4) | 32'h3000);
    wr(A_CT, ct_word(1'b1, 4'h5, 1'b0));            // accepted at E0
    wr(A_CT, ct_word(1'b1, 4'h5, 1'b0));            // accepted at E0+2, must not restart
    rd(A_CT, v);
    chk("R9 busy after repeated start", 32'(v[21]), 32'd1);
    repeat (L - 4) @(negedge clk);
    wr(A_CT, ct_word(1'b0, 4'h5, 1'b1));            // accepted at E0+L, the completion edge
    model_done(7, 1'b1, 4, 1'b1);
    rd(A_CT, v);
    chk("R9 completes on original schedule", 32'(v[21]), 32'd0);
    chk("R5 set wins over clear on same edge", 32'(v[0]), 32'd1);
    chk_outputs("R4 core0 kept, core1 applied");
    @(negedge clk);
    rd(A_CT, v);
    chk("R9 no late restart", 32'(v[21]), 32'd0);
    wr(A_CT, ct_word(1'b0, 4'h0, 1'b1));
    rd(A_CT, v);
    chk("R5 cleared afterwards", v, 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule